// File: doc/BRIEF.md
# Loopback and Diagnostic Path Selector

This block sits between the line-code encoder, the line driver, the clock-and-data recovery output and the line-code decoder of a single-channel line interface. Every stream is a pair of mark rails: a positive mark is p=1, n=0, a negative mark is p=0, n=1, and a space is both rails low. The block chooses what the line driver sends and what the decoder receives. The choices are normal operation, three loopback modes and two all-ones test patterns, and they follow a fixed priority.

The control pins are taken only at bit boundaries. The environment marks each boundary with a one-cycle `bit_en` strobe. A new route therefore always starts at the beginning of a bit, and no mark is ever cut short. Both outputs are registered, so each output follows its inputs one clock later. The all-ones pattern alternates polarity at every bit boundary. It has the form of an AMI-coded all-ones signal, and it runs even while no path uses it.

Top module: `diag_path_sel`

## Requirements
- R1: After a reset, both outputs are spaces (all four rails 0) and the route is normal. The first all-ones mark after reset is positive when `ONES_FIRST_POS` is 1.
- R2: With no loopback enable low and no all-ones enable high, `ltx` equals the encoder rails of the previous cycle and `dec` equals the recovered line rails of the previous cycle.
- R3: With `loc_lb_n` low, `dec` carries the same value as `ltx` in every cycle and the recovered line rails are ignored. Local loopback takes priority over remote and digital loopback, so `ltx` stays on the encoder.
- R4: With `rem_lb_n` low and local loopback off, `ltx` is the previous cycle's recovered line rails and the encoder rails are ignored. `dec` still carries the line rails to the terminal side.
- R5: With `dig_lb_n` low and local loopback off, `dec` is the previous cycle's encoder rails and the line rails are ignored. `ltx` stays on the encoder.
- R6: With `tx_ones` high, `ltx` carries the all-ones pattern whatever the loopback enables are, remote loopback included.
- R7: With `rx_ones` high, `dec` carries the all-ones pattern whatever the loopback enables are, digital and local loopback included.
- R8: The control pins are sampled only in cycles where `bit_en` is 1. A control change between two boundaries has no effect on either output until the next boundary.
- R9: The all-ones pattern holds one mark for a whole bit, and the mark changes polarity at every `bit_en` cycle whether or not any path uses it. Both paths see the same polarity in the same bit.
- R10: With local loopback and `tx_ones` both active, `dec` receives the all-ones pattern that `ltx` sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit boundary strobe, one cycle per bit |
| loc_lb_n | input | 1 | Local loopback enable, active low |
| rem_lb_n | input | 1 | Remote loopback enable, active low |
| dig_lb_n | input | 1 | Digital loopback enable, active low |
| tx_ones | input | 1 | Transmit all-ones enable, active high |
| rx_ones | input | 1 | Receive all-ones enable, active high |
| enc_p | input | 1 | Encoder output, positive rail |
| enc_n | input | 1 | Encoder output, negative rail |
| lrx_p | input | 1 | Recovered line data, positive rail |
| lrx_n | input | 1 | Recovered line data, negative rail |
| ltx_p | output | 1 | To line driver, positive rail |
| ltx_n | output | 1 | To line driver, negative rail |
| dec_p | output | 1 | To decoder, positive rail |
| dec_n | output | 1 | To decoder, negative rail |

## Verification
Two functions can fall in the same cycle. In the first case, local loopback is active while transmit all-ones is on, so the decoder must receive the exact alternating marks that go to the line in that same cycle. In the second case, a control change lands on the bit boundary where the all-ones polarity flips. The bench provokes the first case by enabling both controls together, and the second by changing controls in the middle of a bit and holding them across a boundary. A scoreboard model judges each cycle by applying the priority and the polarity toggle only at the boundaries.

// File: rtl/diag_path_sel_pkg.sv
package diag_path_sel_pkg;

  typedef struct packed {
    logic p;
    logic n;
  } mark_t;

  localparam mark_t MARK_SPACE = '{p: 1'b0, n: 1'b0};
  localparam mark_t MARK_POS   = '{p: 1'b1, n: 1'b0};
  localparam mark_t MARK_NEG   = '{p: 1'b0, n: 1'b1};

  typedef enum logic [1:0] {
    TX_ENC  = 2'd0,
    TX_LINE = 2'd1,
    TX_ONES = 2'd2
  } tx_src_e;

  typedef enum logic [1:0] {
    RX_LINE = 2'd0,
    RX_ENC  = 2'd1,
    RX_LOOP = 2'd2,
    RX_ONES = 2'd3
  } rx_src_e;

  typedef struct packed {
    tx_src_e tx;
    rx_src_e rx;
  } route_t;

  localparam route_t ROUTE_IDLE = '{tx: TX_ENC, rx: RX_LINE};

  // Fixed priority: all-ones beats every loopback on its own side;
  // local beats remote and digital.
  function automatic route_t resolve_route(input logic loc_n, input logic rem_n,
                                           input logic dig_n, input logic ones_t,
                                           input logic ones_r);
    route_t r;
    r = ROUTE_IDLE;
    if (ones_t)                 r.tx = TX_ONES;
    else if (!rem_n && loc_n)   r.tx = TX_LINE;
    if (ones_r)                 r.rx = RX_ONES;
    else if (!loc_n)            r.rx = RX_LOOP;
    else if (!dig_n)            r.rx = RX_ENC;
    return r;
  endfunction

endpackage

// File: rtl/diag_path_sel_mode.sv
module diag_path_sel_mode
  import diag_path_sel_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   bit_en,
  input  route_t route_pins,
  output route_t route_q
);

  always_ff @(posedge clk) begin
    if (rst)         route_q <= ROUTE_IDLE;
    else if (bit_en) route_q <= route_pins;
  end

endmodule

// File: rtl/diag_path_sel_ones.sv
module diag_path_sel_ones
  import diag_path_sel_pkg::*;
#(
  parameter bit FIRST_POS = 1'b1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  bit_en,
  output mark_t ones_now
);

  logic  phase_q;
  mark_t hold_q;
  mark_t fresh;

  assign fresh    = phase_q ? MARK_POS : MARK_NEG;
  assign ones_now = bit_en ? fresh : hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= FIRST_POS;
      hold_q  <= MARK_SPACE;
    end else if (bit_en) begin
      phase_q <= ~phase_q;
      hold_q  <= fresh;
    end
  end

endmodule

// File: rtl/diag_path_sel_route.sv
module diag_path_sel_route
  import diag_path_sel_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   bit_en,
  input  route_t route_pins,
  input  route_t route_q,
  input  mark_t  ones_now,
  input  mark_t  enc,
  input  mark_t  lrx,
  output mark_t  ltx_q,
  output mark_t  dec_q
);

  route_t applied;
  mark_t  tx_d;
  mark_t  rx_d;

  always_comb begin
    applied = bit_en ? route_pins : route_q;
    unique case (applied.tx)
      TX_LINE: tx_d = lrx;
      TX_ONES: tx_d = ones_now;
      default: tx_d = enc;
    endcase
    unique case (applied.rx)
      RX_ENC:  rx_d = enc;
      RX_LOOP: rx_d = tx_d;
      RX_ONES: rx_d = ones_now;
      default: rx_d = lrx;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ltx_q <= MARK_SPACE;
      dec_q <= MARK_SPACE;
    end else begin
      ltx_q <= tx_d;
      dec_q <= rx_d;
    end
  end

endmodule

// File: rtl/diag_path_sel.sv
module diag_path_sel
  import diag_path_sel_pkg::*;
#(
  parameter bit ONES_FIRST_POS = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic loc_lb_n,
  input  logic rem_lb_n,
  input  logic dig_lb_n,
  input  logic tx_ones,
  input  logic rx_ones,
  input  logic enc_p,
  input  logic enc_n,
  input  logic lrx_p,
  input  logic lrx_n,
  output logic ltx_p,
  output logic ltx_n,
  output logic dec_p,
  output logic dec_n
);

  route_t route_pins;
  route_t route_q;
  mark_t  ones_now;
  mark_t  ltx_q;
  mark_t  dec_q;

  assign route_pins = resolve_route(loc_lb_n, rem_lb_n, dig_lb_n, tx_ones, rx_ones);

  diag_path_sel_mode u_mode (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .route_pins (route_pins),
    .route_q    (route_q)
  );

  diag_path_sel_ones #(.FIRST_POS(ONES_FIRST_POS)) u_ones (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .ones_now (ones_now)
  );

  diag_path_sel_route u_route (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .route_pins (route_pins),
    .route_q    (route_q),
    .ones_now   (ones_now),
    .enc        ('{p: enc_p, n: enc_n}),
    .lrx        ('{p: lrx_p, n: lrx_n}),
    .ltx_q      (ltx_q),
    .dec_q      (dec_q)
  );

  assign ltx_p = ltx_q.p;
  assign ltx_n = ltx_q.n;
  assign dec_p = dec_q.p;
  assign dec_n = dec_q.n;

endmodule

// File: rtl/diag_path_sel_chk.sv
module diag_path_sel_chk
  import diag_path_sel_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   bit_en,
  input logic   tx_ones,
  input logic   rx_ones,
  input logic   loc_lb_n,
  input logic   enc_p,
  input logic   enc_n,
  input logic   lrx_p,
  input logic   lrx_n,
  input logic   ltx_p,
  input logic   ltx_n,
  input logic   dec_p,
  input logic   dec_n,
  input route_t route_q
);

  logic run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= 1'b1;
  end

  p_idle_tx_r2: assert property (@(posedge clk) disable iff (rst)
    run_q && route_q.tx == TX_ENC |-> {ltx_p, ltx_n} == $past({enc_p, enc_n}));

  p_local_echo_r3: assert property (@(posedge clk) disable iff (rst)
    run_q && route_q.rx == RX_LOOP |-> {dec_p, dec_n} == {ltx_p, ltx_n});

  p_local_prio_r3: assert property (@(posedge clk) disable iff (rst)
    bit_en && !loc_lb_n && !rx_ones |=> route_q.rx == RX_LOOP);

  p_remote_line_r4: assert property (@(posedge clk) disable iff (rst)
    run_q && route_q.tx == TX_LINE |-> {ltx_p, ltx_n} == $past({lrx_p, lrx_n}));

  p_digital_enc_r5: assert property (@(posedge clk) disable iff (rst)
    run_q && route_q.rx == RX_ENC |-> {dec_p, dec_n} == $past({enc_p, enc_n}));

  p_tx_ones_prio_r6: assert property (@(posedge clk) disable iff (rst)
    bit_en && tx_ones |=> route_q.tx == TX_ONES);

  p_rx_ones_prio_r7: assert property (@(posedge clk) disable iff (rst)
    bit_en && rx_ones |=> route_q.rx == RX_ONES);

  p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
    run_q && !bit_en |=> $stable(route_q));

  p_ones_mark_r9: assert property (@(posedge clk) disable iff (rst)
    run_q && route_q.tx == TX_ONES |-> ltx_p != ltx_n);

endmodule

bind diag_path_sel diag_path_sel_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bit_en   (bit_en),
  .tx_ones  (tx_ones),
  .rx_ones  (rx_ones),
  .loc_lb_n (loc_lb_n),
  .enc_p    (enc_p),
  .enc_n    (enc_n),
  .lrx_p    (lrx_p),
  .lrx_n    (lrx_n),
  .ltx_p    (ltx_p),
  .ltx_n    (ltx_n),
  .dec_p    (dec_p),
  .dec_n    (dec_n),
  .route_q  (route_q)
);

// File: tb/diag_path_sel_bench.sv
module diag_path_sel_bench;

  localparam int BIT_CYC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic loc_lb_n = 1'b1, rem_lb_n = 1'b1, dig_lb_n = 1'b1;
  logic tx_ones = 1'b0, rx_ones = 1'b0;
  logic enc_p = 1'b0, enc_n = 1'b0, lrx_p = 1'b0, lrx_n = 1'b0;
  logic ltx_p, ltx_n, dec_p, dec_n;

  always #2.5 clk = ~clk;

  diag_path_sel u_diag_path_sel (
    .clk(clk), .rst(rst), .bit_en(bit_en),
    .loc_lb_n(loc_lb_n), .rem_lb_n(rem_lb_n), .dig_lb_n(dig_lb_n),
    .tx_ones(tx_ones), .rx_ones(rx_ones),
    .enc_p(enc_p), .enc_n(enc_n), .lrx_p(lrx_p), .lrx_n(lrx_n),
    .ltx_p(ltx_p), .ltx_n(ltx_n), .dec_p(dec_p), .dec_n(dec_n)
  );

  typedef struct {
    logic [1:0] tx;
    logic [1:0] rx;
    string      tag;
  } exp_t;

  exp_t q[$];
  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 0;

  // Bench model state (from the requirements)
  logic [1:0] m_tx = 2'd0;  // 0 enc, 1 line, 2 ones
  logic [1:0] m_rx = 2'd0;  // 0 line, 1 enc, 2 loop, 3 ones
  logic       m_phase = 1'b1;
  logic [1:0] m_hold = 2'b00;

  // Controls the driver applies on its next cycle
  logic c_loc = 1'b1, c_rem = 1'b1, c_dig = 1'b1, c_t1 = 1'b0, c_r1 = 1'b0;

  task automatic step(input string tag);
    logic [1:0] ones, e, l, tx, rx;
    @(negedge clk);
    bit_en = (cyc % BIT_CYC) == 0;
    loc_lb_n = c_loc; rem_lb_n = c_rem; dig_lb_n = c_dig;
    tx_ones = c_t1; rx_ones = c_r1;
    e = 2'($urandom_range(0, 2)); l = 2'($urandom_range(0, 2));
    {enc_p, enc_n} = e; {lrx_p, lrx_n} = l;
    if (bit_en) begin
      m_tx = c_t1 ? 2'd2 : (!c_rem && c_loc) ? 2'd1 : 2'd0;
      m_rx = c_r1 ? 2'd3 : !c_loc ? 2'd2 : !c_dig ? 2'd1 : 2'd0;
      ones = m_phase ? 2'b10 : 2'b01;
      m_phase = ~m_phase;
      m_hold = ones;
    end else begin
      ones = m_hold;
    end
    tx = (m_tx == 2'd2) ? ones : (m_tx == 2'd1) ? l : e;
    rx = (m_rx == 2'd3) ? ones : (m_rx == 2'd2) ? tx : (m_rx == 2'd1) ? e : l;
    q.push_back('{tx: tx, rx: rx, tag: tag});
    cyc++;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic align(input int ph, input string tag);
    while ((cyc % BIT_CYC) != ph) step(tag);
  endtask

  task automatic set_ctl(input logic l, input logic r, input logic d,
                         input logic t1, input logic r1);
    c_loc = l; c_rem = r; c_dig = d; c_t1 = t1; c_r1 = r1;
  endtask

  // Monitor: compare design output against queued expectations
  always @(posedge clk) begin
    #1;
    if (!rst && q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      compared++;
      if ({ltx_p, ltx_n} !== x.tx || {dec_p, dec_n} !== x.rx) begin
        mismatched++;
        $display("FAIL %s: ltx=%b dec=%b expected ltx=%b dec=%b",
                 x.tag, {ltx_p, ltx_n}, {dec_p, dec_n}, x.tx, x.rx);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state, all rails low
    compared++;
    if ({ltx_p, ltx_n, dec_p, dec_n} !== 4'b0000) begin
      mismatched++;
      $display("FAIL R1: rails=%b expected=0000", {ltx_p, ltx_n, dec_p, dec_n});
    end
    @(negedge clk);
    rst = 1'b0;
    // R1: first all-ones mark after reset is positive
    set_ctl(1, 1, 1, 1, 0);
    run(8, "R1");
    set_ctl(1, 1, 1, 0, 0);
    run(40, "R2");
    set_ctl(0, 1, 1, 0, 0);
    run(40, "R3");
    set_ctl(0, 0, 0, 0, 0);
    run(40, "R3 priority");
    set_ctl(1, 0, 1, 0, 0);
    run(40, "R4");
    set_ctl(1, 1, 0, 0, 0);
    run(40, "R5");
    set_ctl(1, 1, 1, 1, 0);
    run(40, "R6");
    set_ctl(1, 0, 1, 1, 0);
    run(40, "R6 over remote");
    set_ctl(1, 1, 0, 0, 1);
    run(40, "R7 over digital");
    set_ctl(0, 1, 1, 0, 1);
    run(40, "R7 over local");
    set_ctl(0, 1, 1, 1, 0);
    run(40, "R10");
    set_ctl(1, 1, 1, 1, 1);
    run(40, "R9");
    set_ctl(1, 1, 1, 0, 0);
    run(8, "R2");
    // R8: change mid-bit, effect only at next boundary
    align(2, "R8");
    set_ctl(1, 1, 0, 0, 0);
    run(12, "R8");
    // R8: a remote pulse fully inside one bit has no effect
    align(1, "R8");
    set_ctl(1, 0, 0, 0, 0);
    run(2, "R8 pulse");
    set_ctl(1, 1, 0, 0, 0);
    run(12, "R8 pulse");
    // R9: mode switch on the boundary where polarity flips
    align(3, "R9");
    set_ctl(1, 1, 1, 0, 1);
    run(20, "R9 switch");
    set_ctl(1, 1, 1, 0, 0);
    run(4, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule